// File: doc/BRIEF.md
# Accumulator Mid-Word Logical Shift Unit

This execution unit sits in a DSP-style datapath. It holds two 56-bit accumulators, here called A and B, and a 16-bit status register. On a start strobe it shifts the middle 24-bit field (bits 47..24) of the selected accumulator left by one position and fills the vacated bit with zero. The 8-bit extension field (bits 55..48) and the 24-bit low field (bits 23..0) are left untouched. It then rewrites the condition-code flags from that middle field alone.

A shift count of zero is also supported. In that case the accumulator keeps its value and the carry flag is cleared. An external limit indication, raised when a concurrent parallel move clamped its data, is folded into the status register. Preset ports load either accumulator and the status register while the unit is idle.

One operation occupies two clock cycles. The result and a one-cycle done pulse appear together in the second cycle.

Top module: `midShiftUnit`

## Requirements
- R1: After reset both accumulators and the status register read zero and doneOut is low.
- R2: An operation with a non-zero count replaces bits 47..24 of the selected accumulator with those bits shifted left by one, with zero entering bit 24; bits 55..48 and 23..0 keep their values.
- R3: The carry flag (status bit 0) takes the value bit 47 of the selected accumulator held before the operation.
- R4: The negative flag (status bit 3) equals bit 47 of the result, and the zero flag (status bit 2) is set exactly when result bits 47..24 are all zero, regardless of the other bits.
- R5: The overflow flag (status bit 1) is zero after every operation.
- R6: The limit flag (status bit 6) is set when limitIn is high with the accepted start; otherwise it keeps its previous value (it is sticky).
- R7: Status bits 15..7, bit 5 and bit 4 are unchanged by an operation.
- R8: With zeroCount high the selected accumulator is unchanged, the carry flag is cleared, and N, Z and V follow R4 and R5 for the unchanged field.
- R9: A start sampled at clock edge k while idle produces the updated accumulator and status after edge k+1, with doneOut high for exactly the one cycle between edges k+1 and k+2.
- R10: A start strobe sampled while an operation is in progress is ignored: it produces no further operation and no further done pulse.
- R11: Preset loads (loadAccA, loadAccB, loadStatus) take effect at the next edge when the unit is idle, and are ignored while an operation is in progress.
- R12: The accumulator that is not selected (accSel 0 selects A, 1 selects B) is unchanged by an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an operation when idle |
| accSel | input | 1 | 0 selects accumulator A, 1 selects B |
| zeroCount | input | 1 | Shift count of zero for this operation |
| limitIn | input | 1 | Parallel move reports data limiting |
| loadAccA | input | 1 | Preset accumulator A from presetAcc |
| loadAccB | input | 1 | Preset accumulator B from presetAcc |
| loadStatus | input | 1 | Preset status register from presetStatus |
| presetAcc | input | 56 | Accumulator preset value |
| presetStatus | input | 16 | Status register preset value |
| accA | output | 56 | Accumulator A |
| accB | output | 56 | Accumulator B |
| statusReg | output | 16 | Status register |
| doneOut | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties assume that the select, count and limit inputs are only meaningful in the cycle where a start is accepted. They also assume that a preset and a start may overlap at an idle edge, with the preset landing first. The directed stimulus changes inputs only on falling edges. It raises the start strobe for a single idle edge, except in the scenario that deliberately holds start and a preset high across the busy edges. That scenario checks that neither has any effect there. Expected accumulator and status values come from a small bench-side model of the field shift and flag rules, and the worked example from the requirements is also checked with its literal values.

// File: rtl/midShiftPkg.sv
package midShiftPkg;
  // condition-code bit positions used by the flag logic
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_L = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;    // write the shift result at this edge
    logic selB;      // operate on accumulator B
    logic zeroCnt;   // shift count of zero
    logic limitHit;  // parallel move limited its data
    logic loadOk;    // presets may be accepted
  } strobeT;
endpackage

// File: rtl/midShiftCtrl.sv
module midShiftCtrl
  import midShiftPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startPulse,
  input  logic   accSel,
  input  logic   zeroCount,
  input  logic   limitIn,
  output strobeT strobe,
  output logic   doneOut
);
  stateT state, stateNext;
  logic  selR, zeroR, limR;
  logic  accept;

  assign accept = (state == ST_IDLE) && startPulse;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (startPulse) stateNext = ST_RUN;
      ST_RUN:  stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selR  <= 1'b0;
      zeroR <= 1'b0;
      limR  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        selR  <= accSel;
        zeroR <= zeroCount;
        limR  <= limitIn;
      end
    end
  end

  always_comb begin
    strobe.commit   = (state == ST_RUN);
    strobe.selB     = selR;
    strobe.zeroCnt  = zeroR;
    strobe.limitHit = limR;
    strobe.loadOk   = (state == ST_IDLE);
  end

  assign doneOut = (state == ST_FIN);

  // R9: done is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R9: an accepted start leads to the execute cycle, then done
  assert_start_to_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startPulse) |=> strobe.commit);

  assert_run_to_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> doneOut);

  // R10: operands captured at start do not move while busy
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> ($stable(selR) && $stable(zeroR) && $stable(limR)));

  // R10: after done the unit returns to idle, never to a second run
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> strobe.loadOk);
endmodule

// File: rtl/midShiftPath.sv
module midShiftPath
  import midShiftPkg::*;
#(
  parameter int ACC_W  = 56,
  parameter int MID_HI = 47,
  parameter int MID_LO = 24,
  parameter int SR_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic             loadAccA,
  input  logic             loadAccB,
  input  logic             loadStatus,
  input  logic [ACC_W-1:0] presetAcc,
  input  logic [SR_W-1:0]  presetStatus,
  output logic [ACC_W-1:0] accA,
  output logic [ACC_W-1:0] accB,
  output logic [SR_W-1:0]  statusReg
);
  localparam int FLD_W  = MID_HI - MID_LO + 1;
  localparam int N_ACC  = 2;

  logic [ACC_W-1:0] accR [N_ACC];
  logic [SR_W-1:0]  statusR;

  logic [ACC_W-1:0] srcAcc, newAcc;
  logic [FLD_W-1:0] srcFld, resFld;
  logic             carryNew;
  logic [SR_W-1:0]  newStatus;

  always_comb begin
    srcAcc   = strobe.selB ? accR[1] : accR[0];
    srcFld   = srcAcc[MID_HI:MID_LO];
    resFld   = strobe.zeroCnt ? srcFld : {srcFld[FLD_W-2:0], 1'b0};
    carryNew = strobe.zeroCnt ? 1'b0 : srcFld[FLD_W-1];
    newAcc   = srcAcc;
    newAcc[MID_HI:MID_LO] = resFld;

    newStatus        = statusR;
    newStatus[FLG_C] = carryNew;
    newStatus[FLG_V] = 1'b0;
    newStatus[FLG_Z] = ~|resFld;
    newStatus[FLG_N] = resFld[FLD_W-1];
    newStatus[FLG_L] = statusR[FLG_L] | strobe.limitHit;
  end

  for (genvar g = 0; g < N_ACC; g++) begin : gAcc
    logic loadThis;
    logic pickThis;
    assign loadThis = (g == 0) ? loadAccA : loadAccB;
    assign pickThis = (strobe.selB == 1'(g));
    always_ff @(posedge clk) begin
      if (!rstN)
        accR[g] <= '0;
      else if (strobe.loadOk && loadThis)
        accR[g] <= presetAcc;
      else if (strobe.commit && pickThis)
        accR[g] <= newAcc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      statusR <= '0;
    else if (strobe.loadOk && loadStatus)
      statusR <= presetStatus;
    else if (strobe.commit)
      statusR <= newStatus;
  end

  assign accA      = accR[0];
  assign accB      = accR[1];
  assign statusReg = statusR;

  // R5: overflow is clear after an operation
  assert_v_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !statusReg[FLG_V]);

  // R7: mode byte, reserved bit and E/U untouched
  assert_mode_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (statusReg[SR_W-1:7] == $past(statusReg[SR_W-1:7])
                       && statusReg[5:4] == $past(statusReg[5:4])));

  // R2: outer fields of the selected accumulator keep their value
  assert_outer_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !strobe.selB) |=>
      (accA[ACC_W-1:MID_HI+1] == $past(accA[ACC_W-1:MID_HI+1])
       && accA[MID_LO-1:0] == $past(accA[MID_LO-1:0])));

  // R3: carry follows the old top bit of the field
  assert_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.selB && !strobe.zeroCnt) |=>
      (statusReg[FLG_C] == $past(accB[MID_HI])));

  // R8: zero count leaves the accumulator alone and clears carry
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.zeroCnt) |=>
      ($stable(accA) && $stable(accB) && !statusReg[FLG_C]));

  // R12: the other accumulator is untouched
  assert_other_keep_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && strobe.selB) |=> $stable(accA));

  // R11: without idle acceptance or commit nothing moves
  assert_load_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadOk && !strobe.commit) |=>
      ($stable(accA) && $stable(accB) && $stable(statusReg)));
endmodule

// File: rtl/midShiftUnit.sv
module midShiftUnit
  import midShiftPkg::*;
#(
  parameter int ACC_W  = 56,
  parameter int MID_HI = 47,
  parameter int MID_LO = 24,
  parameter int SR_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             accSel,
  input  logic             zeroCount,
  input  logic             limitIn,
  input  logic             loadAccA,
  input  logic             loadAccB,
  input  logic             loadStatus,
  input  logic [ACC_W-1:0] presetAcc,
  input  logic [SR_W-1:0]  presetStatus,
  output logic [ACC_W-1:0] accA,
  output logic [ACC_W-1:0] accB,
  output logic [SR_W-1:0]  statusReg,
  output logic             doneOut
);
  strobeT strobe;

  midShiftCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .accSel     (accSel),
    .zeroCount  (zeroCount),
    .limitIn    (limitIn),
    .strobe     (strobe),
    .doneOut    (doneOut)
  );

  midShiftPath #(
    .ACC_W  (ACC_W),
    .MID_HI (MID_HI),
    .MID_LO (MID_LO),
    .SR_W   (SR_W)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .loadAccA     (loadAccA),
    .loadAccB     (loadAccB),
    .loadStatus   (loadStatus),
    .presetAcc    (presetAcc),
    .presetStatus (presetStatus),
    .accA         (accA),
    .accB         (accB),
    .statusReg    (statusReg)
  );

  // R1: nothing is reported done right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!doneOut && statusReg == '0));
endmodule

// File: tb/midShiftUnit_bench.sv
`timescale 1ns/1ps
module midShiftUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0, accSel = 1'b0, zeroCount = 1'b0, limitIn = 1'b0;
  logic        loadAccA = 1'b0, loadAccB = 1'b0, loadStatus = 1'b0;
  logic [55:0] presetAcc = '0;
  logic [15:0] presetStatus = '0;
  logic [55:0] accA, accB;
  logic [15:0] statusReg;
  logic        doneOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [55:0] expA, expB;
  logic [15:0] expSR;

  always #10 clk = ~clk;

  midShiftUnit u_midShiftUnit (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .accSel(accSel),
    .zeroCount(zeroCount), .limitIn(limitIn), .loadAccA(loadAccA),
    .loadAccB(loadAccB), .loadStatus(loadStatus), .presetAcc(presetAcc),
    .presetStatus(presetStatus), .accA(accA), .accB(accB),
    .statusReg(statusReg), .doneOut(doneOut)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench-side rule model
  task automatic model(input bit sel, input bit zc, input bit lim);
    logic [55:0] src;
    logic [23:0] fld, res;
    bit c;
    src = sel ? expB : expA;
    fld = src[47:24];
    res = zc ? fld : {fld[22:0], 1'b0};
    c   = zc ? 1'b0 : fld[23];
    src[47:24] = res;
    if (sel) expB = src; else expA = src;
    expSR = {expSR[15:7], expSR[6] | lim, expSR[5:4], res[23], (res == 24'd0), 1'b0, c};
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " accA"}, {8'h0, accA}, {8'h0, expA});
    chk({tag, " accB"}, {8'h0, accB}, {8'h0, expB});
    chk({tag, " status"}, {48'h0, statusReg}, {48'h0, expSR});
  endtask

  task automatic preset(input logic [55:0] a, input logic [55:0] b, input logic [15:0] sr);
    @(negedge clk);
    loadAccA = 1'b1; presetAcc = a;
    @(negedge clk);
    loadAccA = 1'b0; loadAccB = 1'b1; presetAcc = b;
    loadStatus = 1'b1; presetStatus = sr;
    @(negedge clk);
    loadAccB = 1'b0; loadStatus = 1'b0;
    expA = a; expB = b; expSR = sr;
    checkAll("R11 idle preset");
  endtask

  task automatic runOp(input string tag, input bit sel, input bit zc, input bit lim);
    @(negedge clk);
    startPulse = 1'b1; accSel = sel; zeroCount = zc; limitIn = lim;
    @(negedge clk);                       // edge k passed
    startPulse = 1'b0; zeroCount = 1'b0; limitIn = 1'b0;
    chk({tag, " R9 no early done"}, {63'h0, doneOut}, 64'h0);
    @(negedge clk);                       // edge k+1 passed
    chk({tag, " R9 done"}, {63'h0, doneOut}, 64'h1);
    model(sel, zc, lim);
    checkAll(tag);
    @(negedge clk);
    chk({tag, " R9 done falls"}, {63'h0, doneOut}, 64'h0);
  endtask

  task automatic testReset;
    chk("R1 accA", {8'h0, accA}, 64'h0);
    chk("R1 accB", {8'h0, accB}, 64'h0);
    chk("R1 status", {48'h0, statusReg}, 64'h0);
    chk("R1 done", {63'h0, doneOut}, 64'h0);
  endtask

  task automatic testExample;
    preset(56'h11_223344_556677, 56'h00_F01234_13579B, 16'h0300);
    runOp("R2 R3 R4 example", 1'b1, 1'b0, 1'b0);
    chk("R2 literal B", {8'h0, accB}, 64'h00_00_E02468_13579B);
    chk("R3 literal SR", {48'h0, statusReg}, 64'h0309);
    chk("R12 A kept", {8'h0, accA}, 64'h0011_223344_556677);
  endtask

  task automatic testLimitAndA;
    preset(56'hAB_3FFFFF_FFFFFF, 56'hCD_123456_789ABC, 16'hA5B2);
    runOp("R6 R7 R12 A limit", 1'b0, 1'b0, 1'b1);
    chk("R6 L set", {63'h0, statusReg[6]}, 64'h1);
    chk("R7 EU kept", {62'h0, statusReg[5:4]}, {62'h0, 2'b11});
    runOp("R6 sticky L", 1'b0, 1'b0, 1'b0);
    chk("R6 L kept", {63'h0, statusReg[6]}, 64'h1);
  endtask

  task automatic testZeroField;
    preset(56'hFF_800000_FFFFFF, 56'h0, 16'h0002);
    runOp("R4 R5 zero field", 1'b0, 1'b0, 1'b0);
    chk("R4 Z set", {63'h0, statusReg[2]}, 64'h1);
    chk("R3 C from bit47", {63'h0, statusReg[0]}, 64'h1);
    chk("R5 V clear", {63'h0, statusReg[1]}, 64'h0);
  endtask

  task automatic testZeroCount;
    preset(56'h01_C00001_000000, 56'h7E_000000_123456, 16'hFF0F);
    runOp("R8 zero count B", 1'b1, 1'b1, 1'b0);
    chk("R8 C cleared", {63'h0, statusReg[0]}, 64'h0);
    runOp("R8 zero count A", 1'b0, 1'b1, 1'b1);
    chk("R8 A unchanged", {8'h0, accA}, 64'h0001_C00001_000000);
  endtask

  task automatic testBusy;
    preset(56'h22_400000_000001, 56'h33_812345_000002, 16'h0000);
    @(negedge clk);
    startPulse = 1'b1; accSel = 1'b1;
    @(negedge clk);                       // now busy
    accSel = 1'b0; zeroCount = 1'b1;
    loadAccA = 1'b1; loadStatus = 1'b1;
    presetAcc = 56'h99_999999_999999; presetStatus = 16'hFFFF;
    @(negedge clk);                       // done cycle
    chk("R10 done busy", {63'h0, doneOut}, 64'h1);
    model(1'b1, 1'b0, 1'b0);
    checkAll("R10 R11 busy");
    startPulse = 1'b0; zeroCount = 1'b0; loadAccA = 1'b0; loadStatus = 1'b0;
    @(negedge clk);
    chk("R10 done low", {63'h0, doneOut}, 64'h0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R10 no second done", {63'h0, doneOut}, 64'h0);
    checkAll("R10 R11 after busy");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testExample();
    testLimitAndA();
    testZeroField();
    testZeroCount();
    testBusy();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule